// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block keeps an SDRAM's contents alive by producing AUTO REFRESH commands on time, and it sits between the controller's normal access path and the memory command bus. An interval timer counts clock cycles. At each interval it adds one refresh to a saturating debt counter. In burst mode it uses a longer window instead, and at each window it loads a whole batch of refreshes. While refreshes are owed, the block raises a request. When the access path yields, or the debt reaches its ceiling, the block takes the bus. It then issues one precharge-all and waits the precharge recovery time. It then issues AUTO REFRESH commands, each followed by the refresh cycle time, until the debt is zero. Only then does it hand the bus back.

All timing values are given in nanoseconds (the window in microseconds) and are converted to cycle counts during elaboration. Recovery times round up, with a floor of two cycles. The refresh interval and the window round down, so that refreshes come no later than required. Commands use the four active-low strobes {chip select, row strobe, column strobe, write enable}. While the access path owns the bus, its command and address pass straight through.

Top module: `sdr_refresh_sched`

## Requirements
- R1: After reset no refresh is owed: `acc_gnt`=1, `ref_req`=0, `ref_urgent`=0, and the bus carries the access path's command and address.
- R2: In distributed mode one refresh becomes owed every interval. With `acc_yield` held high, every owed refresh is issued, so one AUTO REFRESH follows each interval.
- R3: While `acc_gnt`=1, `sd_cmd` equals `acc_cmd` and `sd_addr` equals `acc_addr` in the same cycle.
- R4: When a refresh is owed and `acc_yield` is high, or the debt is full, the next cycle drops `acc_gnt` and drives PRECHARGE (4'b0010) with address bit 10 set and all other address bits zero. Every takeover starts with this command.
- R5: The first AUTO REFRESH (4'b0001) comes exactly the recovery count of cycles after the precharge. NOP (4'b0111) is driven in between. The address is all zeros during AUTO REFRESH.
- R6: After each AUTO REFRESH, the next AUTO REFRESH or the return of `acc_gnt` comes exactly the refresh-cycle count of cycles later. NOP is driven in between.
- R7: One takeover drains the whole debt with a single precharge. AUTO REFRESH is never issued with zero debt.
- R8: The debt saturates at DEBT_MAX. `ref_urgent` is high exactly when the debt is at DEBT_MAX. At that level the bus is taken without `acc_yield`.
- R9: When an interval tick and an AUTO REFRESH fall in the same cycle, the debt is unchanged, even at saturation.
- R10: With `burst_mode`=1, each window loads BURST_N owed refreshes. They are issued back to back at refresh-cycle spacing after a single precharge.
- R11: Cycle counts come from the nanosecond parameters. Recovery times round up, with a minimum of 2. The interval and the window round down. At 50 MHz, 30 ns gives 2, 90 ns gives 5 and 510 ns gives 25.
- R12: `ref_req` is high while any refresh is owed or the block owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 0: one refresh per interval; 1: a batch per window |
| acc_yield | input | 1 | Access path has parked and allows a takeover |
| acc_cmd | input | 4 | Access path command {cs_n, ras_n, cas_n, we_n} |
| acc_addr | input | ADDR_W | Access path address |
| ref_req | output | 1 | Refresh owed or in progress |
| ref_urgent | output | 1 | Debt at ceiling; the bus is taken without yield |
| acc_gnt | output | 1 | Access path owns the command bus |
| sd_cmd | output | 4 | Command to SDRAM {cs_n, ras_n, cas_n, we_n} |
| sd_addr | output | ADDR_W | Address to SDRAM |

## Verification
The collision of interest is between an interval tick, which adds to the debt, and an AUTO REFRESH, which removes one in the same clock. The bench lets three refreshes build up with the access path refusing. It then raises `acc_yield` so that the precharge lands at cycle 92. The second refresh of that drain then retires on cycle 100, the same edge as the fourth tick. A debt model in the bench, driven only by its own cycle count and the commands seen on the bus, must match `ref_req` and `ref_urgent` every cycle. It must also count that collision at least once, and the total number of refreshes must be exactly four.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;
  // command encoding {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] SDC_REF = 4'b0001;
  localparam logic [3:0] SDC_PRE = 4'b0010;
  localparam logic [3:0] SDC_NOP = 4'b0111;

  // recovery time: round up, never fewer than two cycles
  function automatic int unsigned rec_cycles(longint unsigned t_ns, longint unsigned clk_ps);
    longint unsigned c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 2) ? 2 : int'(c);
  endfunction

  // deadline period: round down, never fewer than one cycle
  function automatic int unsigned period_cycles(longint unsigned t_ns, longint unsigned clk_ps);
    longint unsigned c;
    c = (t_ns * 1000) / clk_ps;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int unsigned imax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int unsigned PER_DIST  = 2083,
  parameter int unsigned PER_BURST = 8533333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  output logic tick
);
  import sdr_ref_pkg::*;
  localparam int unsigned CNT_W = $clog2(imax(PER_DIST, PER_BURST) + 1);
  localparam logic [CNT_W-1:0] LIM_D = CNT_W'(PER_DIST - 1);
  localparam logic [CNT_W-1:0] LIM_B = CNT_W'(PER_BURST - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = burst_mode ? LIM_B : LIM_D;
  assign tick  = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdr_ref_debt.sv
module sdr_ref_debt #(
  parameter int unsigned DEBT_MAX = 8,
  parameter int unsigned BURST_N  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic tick,
  input  logic dec,
  output logic owed_nz,
  output logic urgent
);
  import sdr_ref_pkg::*;
  localparam int unsigned OW_W = $clog2(imax(DEBT_MAX, BURST_N) + 1);
  localparam logic [OW_W-1:0] CAP  = OW_W'(DEBT_MAX);
  localparam logic [OW_W-1:0] LOAD = OW_W'(BURST_N);

  logic [OW_W-1:0] owed_q, owed_d;
  logic inc;

  always_comb begin
    inc = tick && !burst_mode && ((owed_q < CAP) || dec);
    if (tick && burst_mode) owed_d = LOAD;
    else                    owed_d = owed_q + OW_W'(inc) - OW_W'(dec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  assign owed_nz = (owed_q != '0);
  assign urgent  = (owed_q >= CAP);

  // R8
  debt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_mode |-> owed_q <= CAP);
  // R9
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dec && !burst_mode) |=> $stable(owed_q));
endmodule

// File: rtl/sdr_ref_seq.sv
module sdr_ref_seq #(
  parameter int unsigned RP_CYC  = 3,
  parameter int unsigned RFC_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed_nz,
  input  logic urgent,
  input  logic acc_yield,
  output logic issue_pre,
  output logic issue_ref,
  output logic busy
);
  import sdr_ref_pkg::*;
  localparam int unsigned TW = $clog2(imax(RP_CYC, RFC_CYC) + 1);
  localparam logic [TW-1:0] RP_LD  = TW'(RP_CYC - 1);
  localparam logic [TW-1:0] RFC_LD = TW'(RFC_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_WRP, S_REF, S_WRFC} st_e;
  st_e st_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      tmr_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (owed_nz && (acc_yield || urgent)) st_q <= S_PRE;
        S_PRE: begin
          tmr_q <= RP_LD;
          st_q  <= S_WRP;
        end
        S_WRP: begin
          if (tmr_q == TW'(1)) st_q <= S_REF;
          else                 tmr_q <= tmr_q - 1'b1;
        end
        S_REF: begin
          tmr_q <= RFC_LD;
          st_q  <= S_WRFC;
        end
        S_WRFC: begin
          if (tmr_q == TW'(1)) st_q <= owed_nz ? S_REF : S_IDLE;
          else                 tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign issue_pre = (st_q == S_PRE);
  assign issue_ref = (st_q == S_REF);
  assign busy      = (st_q != S_IDLE);

  // R4
  takeover_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> issue_pre);
  // R5
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pre |=> !issue_ref);
  // R6
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ref |=> busy && !issue_ref);
endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched #(
  parameter int unsigned CLK_PERIOD_PS = 7500,
  parameter int unsigned T_RP_NS       = 20,
  parameter int unsigned T_RFC_NS      = 66,
  parameter int unsigned T_REFI_NS     = 15625,
  parameter int unsigned T_WINDOW_US   = 64000,
  parameter int unsigned BURST_N       = 4096,
  parameter int unsigned DEBT_MAX      = 8,
  parameter int unsigned ADDR_W        = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode,
  input  logic              acc_yield,
  input  logic [3:0]        acc_cmd,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              acc_gnt,
  output logic [3:0]        sd_cmd,
  output logic [ADDR_W-1:0] sd_addr
);
  import sdr_ref_pkg::*;
  localparam int unsigned RP_CYC  = rec_cycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned RFC_CYC = rec_cycles(T_RFC_NS, CLK_PERIOD_PS);
  localparam int unsigned PER_D   = period_cycles(T_REFI_NS, CLK_PERIOD_PS);
  localparam int unsigned PER_B   = period_cycles(longint'(T_WINDOW_US) * 1000, CLK_PERIOD_PS);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  logic tick, owed_nz, urgent, issue_pre, issue_ref, busy;

  sdr_ref_timer #(.PER_DIST(PER_D), .PER_BURST(PER_B)) u_timer (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .tick(tick));

  sdr_ref_debt #(.DEBT_MAX(DEBT_MAX), .BURST_N(BURST_N)) u_debt (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .tick(tick),
    .dec(issue_ref), .owed_nz(owed_nz), .urgent(urgent));

  sdr_ref_seq #(.RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .owed_nz(owed_nz), .urgent(urgent),
    .acc_yield(acc_yield), .issue_pre(issue_pre), .issue_ref(issue_ref),
    .busy(busy));

  always_comb begin
    if (!busy) begin
      sd_cmd  = acc_cmd;
      sd_addr = acc_addr;
    end else if (issue_pre) begin
      sd_cmd  = SDC_PRE;
      sd_addr = ALL_BANKS;
    end else begin
      sd_cmd  = issue_ref ? SDC_REF : SDC_NOP;
      sd_addr = '0;
    end
  end

  assign acc_gnt    = !busy;
  assign ref_req    = owed_nz || busy;
  assign ref_urgent = urgent;

  // R7
  ref_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ref |-> owed_nz);
endmodule

// File: tb/sdr_refresh_sched_tb.sv
module sdr_refresh_sched_tb;
  localparam int AW = 13;
  localparam int E_RP = 2, E_RFC = 5, E_INT = 25, E_WIN = 200, E_BN = 4, E_MAX = 8;

  logic clk = 0, rst_n = 0, burst_mode = 0, acc_yield = 0;
  logic [3:0] acc_cmd = 4'hF;
  logic [AW-1:0] acc_addr = '0;
  logic ref_req, ref_urgent, acc_gnt;
  logic [3:0] sd_cmd;
  logic [AW-1:0] sd_addr;

  sdr_refresh_sched #(.CLK_PERIOD_PS(20000), .T_RP_NS(30), .T_RFC_NS(90),
    .T_REFI_NS(510), .T_WINDOW_US(4), .BURST_N(4), .DEBT_MAX(8), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .acc_yield(acc_yield),
    .acc_cmd(acc_cmd), .acc_addr(acc_addr), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .acc_gnt(acc_gnt), .sd_cmd(sd_cmd), .sd_addr(sd_addr));

  always #10 clk = ~clk;

  int n = 0;
  always @(posedge clk) if (!rst_n) n <= 0; else n <= n + 1;

  int vecs = 0, errs = 0;
  int mo, pre_n, ref_n, ref_total, pre_total, pres_own, coin, first_ref;
  bit last_pre, prev_gnt, done;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  task automatic do_reset(input bit bm);
    rst_n = 0; burst_mode = bm; acc_yield = 0;
    repeat (3) @(negedge clk);
    mo = 0; ref_total = 0; pre_total = 0; pres_own = 0; coin = 0;
    last_pre = 0; prev_gnt = 1; first_ref = -1; pre_n = 0; ref_n = 0;
    rst_n = 1;
  endtask

  // one cycle: check outputs after edge n, then prepare model for edge n+1
  task automatic step();
    int nn;
    bit tk, dc;
    @(negedge clk);
    chk(ref_urgent == (mo >= E_MAX), "R8 urgent", ref_urgent, mo >= E_MAX);
    chk(ref_req == (mo > 0 || !acc_gnt), "R12 req", ref_req, mo > 0 || !acc_gnt);
    if (acc_gnt) begin
      chk(sd_cmd == acc_cmd && sd_addr == acc_addr, "R3 passthrough", sd_cmd, acc_cmd);
      if (!prev_gnt) chk(n - ref_n == E_RFC, "R6 release gap", n - ref_n, E_RFC);
      pres_own = 0;
    end else if (sd_cmd == 4'b0010) begin
      chk(sd_addr == AW'(1 << 10), "R4 precharge addr", sd_addr, 1 << 10);
      pres_own++; pre_total++;
      chk(pres_own == 1, "R7 single precharge", pres_own, 1);
      pre_n = n; last_pre = 1;
    end else if (sd_cmd == 4'b0001) begin
      chk(sd_addr == '0, "R5 refresh addr", sd_addr, 0);
      chk(mo > 0, "R7 refresh with debt", mo, 1);
      if (last_pre) chk(n - pre_n == E_RP, "R5 R11 rp gap", n - pre_n, E_RP);
      else          chk(n - ref_n == E_RFC, "R6 R11 rfc gap", n - ref_n, E_RFC);
      if (first_ref < 0) first_ref = n;
      ref_n = n; last_pre = 0; ref_total++;
    end else begin
      chk(sd_cmd == 4'b0111, "R5 R6 nop fill", sd_cmd, 4'b0111);
    end
    prev_gnt = acc_gnt;
    nn = n + 1;
    dc = (!acc_gnt && sd_cmd == 4'b0001);
    if (burst_mode) begin
      if (nn % E_WIN == 0) mo = E_BN;
      else if (dc) mo--;
    end else begin
      tk = (nn % E_INT == 0);
      if (tk && dc) coin++;
      else if (tk) mo = (mo < E_MAX) ? mo + 1 : mo;
      else if (dc) mo--;
    end
    acc_cmd = 4'(n * 7 + 3);
    acc_addr = AW'(n * 37);
  endtask

  task automatic run_to(input int target);
    while (n < target) step();
  endtask

  task automatic t_reset_state();
    rst_n = 0; acc_cmd = 4'h5; acc_addr = AW'(123);
    repeat (2) @(negedge clk);
    chk(acc_gnt == 1, "R1 gnt", acc_gnt, 1);
    chk(ref_req == 0, "R1 req", ref_req, 0);
    chk(ref_urgent == 0, "R1 urgent", ref_urgent, 0);
    chk(sd_cmd == 4'h5 && sd_addr == AW'(123), "R1 bus", sd_cmd, 5);
  endtask

  task automatic t_passthrough();
    do_reset(0);
    run_to(20);
    chk(ref_total == 0 && acc_gnt, "R3 no refresh early", ref_total, 0);
  endtask

  task automatic t_distributed();
    do_reset(0);
    acc_yield = 1;
    run_to(260);
    chk(ref_total == 10, "R2 one per interval", ref_total, 10);
    chk(pre_total == 10, "R4 precharge per takeover", pre_total, 10);
    chk(first_ref == E_INT + 3, "R11 interval rounding", first_ref, E_INT + 3);
  endtask

  task automatic t_coincide();
    do_reset(0);
    run_to(91);
    acc_yield = 1;
    run_to(120);
    chk(coin > 0, "R9 tick meets refresh", coin, 1);
    chk(ref_total == 4, "R9 refresh total", ref_total, 4);
    chk(pre_total == 1, "R7 one precharge for debt", pre_total, 1);
  endtask

  task automatic t_starve();
    do_reset(0);
    run_to(199);
    chk(acc_gnt == 1 && pre_total == 0, "R8 no takeover below cap", pre_total, 0);
    run_to(260);
    chk(pre_total == 1, "R8 forced takeover", pre_total, 1);
    chk(ref_total == 9, "R8 forced drain", ref_total, 9);
  endtask

  task automatic t_burst();
    do_reset(1);
    acc_yield = 1;
    run_to(199);
    chk(ref_total == 0, "R10 nothing before window", ref_total, 0);
    run_to(420);
    chk(ref_total == 2 * E_BN, "R10 batch count", ref_total, 2 * E_BN);
    chk(pre_total == 2, "R10 one precharge per batch", pre_total, 2);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_passthrough();
    t_distributed();
    t_coincide();
    t_starve();
    t_burst();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule